// File: doc/BRIEF.md
# Two-Port Group-Banked Memory Arbiter

The block sits in front of a memory built from independent 32 KB groups and serves two requesters. The system port reads 128 bits per access and writes 64 bits. The local port reads and writes 64 bits. In every cycle the block works out which group each request targets. Requests to different groups go ahead together. When both target the same group, the local port takes it and the system port is held off with a stall.

A group is driven by at most one port in any cycle. The block brings out a select and a write strobe for each group, a ready for each port, and a stall for the system port. Read data comes back one cycle after a read is accepted, flagged by a per-port return-valid signal.

Storage is a behavioural array in each group. It holds the first `ROWS` 64-bit words of the group, so the byte offsets 0 to `ROWS*8-1` within each group are the ones that are served.

Top module: `bankarb_top`

## Requirements
- R1: The target group of a request is byte address bits [AW-1:15], where AW is the address width. `grp_sel` has exactly one bit set per accepted request, at that request's group. A `grp_we` bit is set only for an accepted write, and only in a group whose `grp_sel` bit is set.
- R2: When both ports request in the same cycle and their groups differ, `sb_ready` and `lb_ready` are both high and `sb_stall` is low.
- R3: A local request is always ready in its cycle. When both ports target one group, `lb_ready` is high, `sb_ready` is low and `sb_stall` is high.
- R4: A stalled system write changes no storage. A local read of the same word in that cycle returns the value held before the write.
- R5: A local read returns the 64-bit word selected by address bits [14:3], ignoring bits [2:0]. The data appears on `lb_rdata` with `lb_rvalid` high in the cycle after acceptance.
- R6: A system read ignores address bits [3:0]. `sb_rdata[63:0]` is the word at the 16-byte-aligned address and `sb_rdata[127:64]` is the next word of the same group. The data appears with `sb_rvalid` high in the cycle after acceptance.
- R7: An accepted write from either port stores its 64-bit data at the word selected by address bits [14:3].
- R8: A stalled system request is held unchanged by the requester. It takes effect exactly once, in the first cycle in which `sb_ready` is high.
- R9: While reset is active and in the cycle after it ends, both return-valid outputs are low. With no requests, `grp_sel` and `grp_we` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sb_req | input | 1 | System port request |
| sb_we | input | 1 | System port write (1) or read (0) |
| sb_addr | input | AW | System port byte address |
| sb_wdata | input | 64 | System port write data |
| sb_ready | output | 1 | System request accepted this cycle |
| sb_stall | output | 1 | System request blocked by a same-group local access |
| sb_rvalid | output | 1 | System read data valid |
| sb_rdata | output | 128 | System read data, two adjacent words |
| lb_req | input | 1 | Local port request |
| lb_we | input | 1 | Local port write (1) or read (0) |
| lb_addr | input | AW | Local port byte address |
| lb_wdata | input | 64 | Local port write data |
| lb_ready | output | 1 | Local request accepted this cycle |
| lb_rvalid | output | 1 | Local read data valid |
| lb_rdata | output | 64 | Local read data |
| grp_sel | output | NUM_GROUPS | Per-group select |
| grp_we | output | NUM_GROUPS | Per-group write strobe |

## Verification
A preload pass of local writes fills every stored word, so every later read has a known expected value. Random traffic then mixes reads and writes from both ports across four groups. Same-group and different-group cycles occur often, which separates the parallel path from the conflict path, and the per-group select and strobe outputs are checked on every cycle. Directed cases pin down three behaviours: a system write held off by a local read of the same word, which shows that the stalled write is neither lost nor applied early; a system read at an odd word with nonzero low address bits, which exercises the alignment rule; and the idle and reset cycles.

// File: rtl/bankarb_pkg.sv
package bankarb_pkg;

  localparam int WORD_W = 64;

  // Group index: the byte address shifted past the in-group offset bits.
  function automatic logic [31:0] group_of(input logic [31:0] addr, input int unsigned gbits);
    return addr >> gbits;
  endfunction

  // Stored row: the 64-bit word index wrapped to the stored depth.
  // For a paired (128-bit) read the row is forced even.
  function automatic logic [31:0] row_of(input logic [31:0] addr, input int unsigned rows,
                                         input bit pair);
    logic [31:0] r;
    r = (addr >> 3) % rows;
    if (pair) r[0] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/bankarb_conflict.sv
module bankarb_conflict #(
  parameter int NUM_GROUPS = 4,
  parameter int GW         = 2
) (
  input  logic                  sb_req,
  input  logic                  sb_we,
  input  logic [GW-1:0]         sb_grp,
  input  logic                  lb_req,
  input  logic                  lb_we,
  input  logic [GW-1:0]         lb_grp,
  output logic                  sb_ready,
  output logic                  sb_stall,
  output logic                  lb_ready,
  output logic [NUM_GROUPS-1:0] grp_sel,
  output logic [NUM_GROUPS-1:0] grp_we,
  output logic [NUM_GROUPS-1:0] grp_lb_owns
);

  logic [NUM_GROUPS-1:0] sb_hit;
  logic [NUM_GROUPS-1:0] lb_hit;
  logic                  sb_block;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign lb_hit[g]      = lb_req && (lb_grp == GW'(g));
    assign sb_hit[g]      = sb_req && (sb_grp == GW'(g));
    assign grp_lb_owns[g] = lb_hit[g];
    assign grp_sel[g]     = lb_hit[g] | sb_hit[g];
    assign grp_we[g]      = lb_hit[g] ? lb_we : (sb_hit[g] & sb_we);
  end

  assign sb_block = |(sb_hit & lb_hit);
  assign lb_ready = lb_req;
  assign sb_ready = sb_req & ~sb_block;
  assign sb_stall = sb_req & sb_block;

endmodule

// File: rtl/bankarb_group.sv
module bankarb_group #(
  parameter int ROWS = 64,
  parameter int RW   = 6
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [63:0]   wdata,
  output logic [63:0]   rd_lo,
  output logic [63:0]   rd_hi
);

  logic [63:0] mem [ROWS];
  logic [RW-1:0] row_next;

  assign row_next = row | RW'(1);

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        mem[row] <= wdata;
      end else begin
        rd_lo <= mem[row];
        rd_hi <= mem[row_next];
      end
    end
  end

endmodule

// File: rtl/bankarb_top.sv
module bankarb_top
  import bankarb_pkg::*;
#(
  parameter int NUM_GROUPS  = 4,
  parameter int GROUP_BYTES = 32768,
  parameter int ROWS        = 64,
  localparam int GB = $clog2(GROUP_BYTES),
  localparam int GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int AW = GB + GW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sb_req,
  input  logic                  sb_we,
  input  logic [AW-1:0]         sb_addr,
  input  logic [63:0]           sb_wdata,
  output logic                  sb_ready,
  output logic                  sb_stall,
  output logic                  sb_rvalid,
  output logic [127:0]          sb_rdata,
  input  logic                  lb_req,
  input  logic                  lb_we,
  input  logic [AW-1:0]         lb_addr,
  input  logic [63:0]           lb_wdata,
  output logic                  lb_ready,
  output logic                  lb_rvalid,
  output logic [63:0]           lb_rdata,
  output logic [NUM_GROUPS-1:0] grp_sel,
  output logic [NUM_GROUPS-1:0] grp_we
);

  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;

  // Named internal events, used by the bound checker.
  logic [GW-1:0] sb_grp;
  logic [GW-1:0] lb_grp;
  logic [RW-1:0] sb_row;
  logic [RW-1:0] lb_row;
  logic          sb_rd_accept;
  logic          lb_rd_accept;
  logic [NUM_GROUPS-1:0] grp_lb_owns;

  assign sb_grp = GW'(group_of(32'(sb_addr), GB));
  assign lb_grp = GW'(group_of(32'(lb_addr), GB));
  assign sb_row = RW'(row_of(32'(sb_addr), ROWS, !sb_we));
  assign lb_row = RW'(row_of(32'(lb_addr), ROWS, 1'b0));

  bankarb_conflict #(.NUM_GROUPS(NUM_GROUPS), .GW(GW)) u_arb (
    .sb_req     (sb_req),
    .sb_we      (sb_we),
    .sb_grp     (sb_grp),
    .lb_req     (lb_req),
    .lb_we      (lb_we),
    .lb_grp     (lb_grp),
    .sb_ready   (sb_ready),
    .sb_stall   (sb_stall),
    .lb_ready   (lb_ready),
    .grp_sel    (grp_sel),
    .grp_we     (grp_we),
    .grp_lb_owns(grp_lb_owns)
  );

  logic [63:0] g_lo [NUM_GROUPS];
  logic [63:0] g_hi [NUM_GROUPS];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
    logic [RW-1:0] row_mux;
    logic [63:0]   wdata_mux;
    assign row_mux   = grp_lb_owns[g] ? lb_row   : sb_row;
    assign wdata_mux = grp_lb_owns[g] ? lb_wdata : sb_wdata;

    bankarb_group #(.ROWS(ROWS), .RW(RW)) u_grp (
      .clk  (clk),
      .en   (grp_sel[g]),
      .we   (grp_we[g]),
      .row  (row_mux),
      .wdata(wdata_mux),
      .rd_lo(g_lo[g]),
      .rd_hi(g_hi[g])
    );
  end

  assign sb_rd_accept = sb_ready & ~sb_we;
  assign lb_rd_accept = lb_ready & ~lb_we;

  logic [GW-1:0] sb_ret_grp;
  logic [GW-1:0] lb_ret_grp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sb_rvalid  <= 1'b0;
      lb_rvalid  <= 1'b0;
      sb_ret_grp <= '0;
      lb_ret_grp <= '0;
    end else begin
      sb_rvalid <= sb_rd_accept;
      lb_rvalid <= lb_rd_accept;
      if (sb_rd_accept) sb_ret_grp <= sb_grp;
      if (lb_rd_accept) lb_ret_grp <= lb_grp;
    end
  end

  assign sb_rdata = {g_hi[sb_ret_grp], g_lo[sb_ret_grp]};
  assign lb_rdata = g_lo[lb_ret_grp];

endmodule

// File: rtl/bankarb_checker.sv
module bankarb_checker #(
  parameter int NUM_GROUPS = 4,
  parameter int GW         = 2,
  parameter int AW         = 17
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sb_req,
  input logic                  sb_we,
  input logic [AW-1:0]         sb_addr,
  input logic [63:0]           sb_wdata,
  input logic                  sb_ready,
  input logic                  sb_stall,
  input logic                  sb_rvalid,
  input logic                  lb_req,
  input logic                  lb_we,
  input logic                  lb_ready,
  input logic                  lb_rvalid,
  input logic [GW-1:0]         sb_grp,
  input logic [GW-1:0]         lb_grp,
  input logic [NUM_GROUPS-1:0] grp_sel,
  input logic [NUM_GROUPS-1:0] grp_we
);

  a_r1_select_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grp_sel) == (int'(sb_ready) + int'(lb_ready)));

  a_r1_strobe_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_we & ~grp_sel) == '0);

  a_r2_parallel: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_req && lb_req && sb_grp != lb_grp) |-> (sb_ready && lb_ready && !sb_stall));

  a_r3_local_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_req && lb_req && sb_grp == lb_grp) |-> (lb_ready && !sb_ready && sb_stall));

  a_r3_local_always: assert property (@(posedge clk) disable iff (!rst_n)
    lb_req |-> lb_ready);

  a_r4_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_ready && lb_ready) |-> (sb_grp != lb_grp));

  a_r5_local_return: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_ready && !lb_we) |=> lb_rvalid);

  a_r6_system_return: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_ready && !sb_we) |=> sb_rvalid);

  a_r8_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    sb_stall |=> (sb_req && $stable(sb_addr) && $stable(sb_we) && $stable(sb_wdata)));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!sb_req && !lb_req) |-> (grp_sel == '0 && grp_we == '0));

endmodule

bind bankarb_top bankarb_checker #(
  .NUM_GROUPS(NUM_GROUPS),
  .GW        (GW),
  .AW        (AW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sb_req   (sb_req),
  .sb_we    (sb_we),
  .sb_addr  (sb_addr),
  .sb_wdata (sb_wdata),
  .sb_ready (sb_ready),
  .sb_stall (sb_stall),
  .sb_rvalid(sb_rvalid),
  .lb_req   (lb_req),
  .lb_we    (lb_we),
  .lb_ready (lb_ready),
  .lb_rvalid(lb_rvalid),
  .sb_grp   (sb_grp),
  .lb_grp   (lb_grp),
  .grp_sel  (grp_sel),
  .grp_we   (grp_we)
);

// File: tb/sim_bankarb_top.sv
module sim_bankarb_top;

  localparam int NG   = 4;
  localparam int GBY  = 32768;
  localparam int ROWS = 64;
  localparam int AW   = 17;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          sb_req, sb_we, sb_ready, sb_stall, sb_rvalid;
  logic [AW-1:0] sb_addr;
  logic [63:0]   sb_wdata;
  logic [127:0]  sb_rdata;
  logic          lb_req, lb_we, lb_ready, lb_rvalid;
  logic [AW-1:0] lb_addr;
  logic [63:0]   lb_wdata, lb_rdata;
  logic [NG-1:0] grp_sel, grp_we;

  bankarb_top u0 (
    .clk(clk), .rst_n(rst_n),
    .sb_req(sb_req), .sb_we(sb_we), .sb_addr(sb_addr), .sb_wdata(sb_wdata),
    .sb_ready(sb_ready), .sb_stall(sb_stall), .sb_rvalid(sb_rvalid), .sb_rdata(sb_rdata),
    .lb_req(lb_req), .lb_we(lb_we), .lb_addr(lb_addr), .lb_wdata(lb_wdata),
    .lb_ready(lb_ready), .lb_rvalid(lb_rvalid), .lb_rdata(lb_rdata),
    .grp_sel(grp_sel), .grp_we(grp_we)
  );

  logic [63:0] model [NG][ROWS];
  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  bit           exp_lbv = 0, exp_sbv = 0;
  logic [63:0]  exp_lbd;
  logic [127:0] exp_sbd;
  bit           last_stall = 0;
  string        note = "";

  function automatic int gof(input logic [AW-1:0] a);
    return int'(a) / GBY;
  endfunction

  function automatic int rof(input logic [AW-1:0] a);
    return (int'(a) / 8) % ROWS;
  endfunction

  function automatic logic [AW-1:0] mk(input int g, input int row, input int b);
    return AW'(g * GBY + row * 8 + b);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", tag, note, act, exp);
    end
  endtask

  task automatic step(input bit sq, input bit sw, input logic [AW-1:0] sa, input logic [63:0] sd,
                      input bit lq, input bit lw, input logic [AW-1:0] la, input logic [63:0] ld);
    int gs, gl, rs, rl, rp;
    bit same, esr;
    logic [NG-1:0] es, ew;
    @(negedge clk);
    sb_req = sq; sb_we = sw; sb_addr = sa; sb_wdata = sd;
    lb_req = lq; lb_we = lw; lb_addr = la; lb_wdata = ld;
    #1;
    // returns from the previous cycle
    chk(lb_rvalid == exp_lbv, "R5 lb_rvalid", 128'(lb_rvalid), 128'(exp_lbv));
    if (exp_lbv) chk(lb_rdata == exp_lbd, "R5 lb_rdata", 128'(lb_rdata), 128'(exp_lbd));
    chk(sb_rvalid == exp_sbv, "R6 sb_rvalid", 128'(sb_rvalid), 128'(exp_sbv));
    if (exp_sbv) chk(sb_rdata == exp_sbd, "R6 sb_rdata", sb_rdata, exp_sbd);
    gs = gof(sa); gl = gof(la); rs = rof(sa); rl = rof(la);
    same = sq && lq && (gs == gl);
    esr  = sq && !same;
    es = '0; ew = '0;
    if (lq) begin es[gl] = 1'b1; ew[gl] = lw; end
    if (esr) begin es[gs] = 1'b1; ew[gs] = sw; end
    chk(lb_ready == lq, "R3 lb_ready", 128'(lb_ready), 128'(lq));
    chk(sb_ready == esr, same ? "R3 sb_ready" : "R2 sb_ready", 128'(sb_ready), 128'(esr));
    chk(sb_stall == (sq && same), same ? "R3 sb_stall" : "R2 sb_stall",
        128'(sb_stall), 128'(sq && same));
    chk(grp_sel == es, "R1 grp_sel", 128'(grp_sel), 128'(es));
    chk(grp_we == ew, "R1 grp_we", 128'(grp_we), 128'(ew));
    exp_lbv = lq && !lw;
    exp_lbd = model[gl][rl];
    exp_sbv = esr && !sw;
    rp = rs - (rs % 2);
    exp_sbd = {model[gs][rp + 1], model[gs][rp]};
    last_stall = sq && !esr;
    @(posedge clk);
    if (lq && lw) model[gl][rl] = ld;      // R7
    if (esr && sw) model[gs][rs] = sd;     // R7, R8: applied once, when ready
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] hs_a;
    logic [63:0]   hs_d;
    bit            hs_q, hs_w;
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0;
    sb_req = 0; sb_we = 0; sb_addr = '0; sb_wdata = '0;
    lb_req = 0; lb_we = 0; lb_addr = '0; lb_wdata = '0;
    repeat (3) @(negedge clk);
    #1;
    note = "reset";
    chk(!lb_rvalid && !sb_rvalid, "R9 rvalid in reset", 128'({sb_rvalid, lb_rvalid}), 128'(0));
    chk(grp_sel == '0, "R9 grp_sel idle", 128'(grp_sel), 128'(0));
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, '0, '0, 0, 0, '0, '0);  // R9: first cycle after reset, rvalid expected low

    note = "preload";
    for (int g = 0; g < NG; g++)
      for (int r = 0; r < ROWS; r++)
        step(0, 0, '0, '0, 1, 1, mk(g, r, 0), {$urandom, $urandom});

    // R4 / R8: system write stalled by a local read of the same word
    note = "R4 stalled write";
    step(1, 1, mk(0, 5, 0), 64'hDEAD_BEEF_0123_4567, 1, 0, mk(0, 5, 0), '0);
    step(1, 1, mk(0, 5, 0), 64'hDEAD_BEEF_0123_4567, 0, 0, '0, '0);
    note = "R8 write landed";
    step(0, 0, '0, '0, 1, 0, mk(0, 5, 0), '0);
    step(0, 0, '0, '0, 0, 0, '0, '0);

    // R6: paired read at an odd word with nonzero low bits, parallel local write elsewhere (R2)
    note = "R6 alignment";
    step(1, 0, mk(2, 9, 13 - 8), '0, 1, 1, mk(3, 9, 0), 64'h1111_2222_3333_4444);
    step(1, 0, mk(1, 63, 7), '0, 1, 0, mk(2, 8, 3), '0);
    step(0, 0, '0, '0, 0, 0, '0, '0);

    // random traffic
    note = "random";
    hs_q = 0; hs_w = 0; hs_a = '0; hs_d = '0;
    for (int i = 0; i < 4000; i++) begin
      bit lq, lw;
      logic [AW-1:0] la;
      if (!last_stall) begin   // R8: a stalled request stays put
        hs_q = ($urandom % 4) != 0;
        hs_w = $urandom % 2;
        hs_a = mk($urandom % NG, $urandom % ROWS, $urandom % 8);
        hs_d = {$urandom, $urandom};
      end
      lq = ($urandom % 3) != 0;
      lw = $urandom % 2;
      la = mk($urandom % NG, $urandom % ROWS, $urandom % 8);
      step(hs_q, hs_w, hs_a, hs_d, lq, lw, la, {$urandom, $urandom});
    end
    note = "drain";
    step(0, 0, '0, '0, 0, 0, '0, '0);
    step(0, 0, '0, '0, 0, 0, '0, '0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule